// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Table Fallback

This block turns a virtual address into a physical address. The upper bits of the virtual address form a page number and the lower bits form an offset. The page number is compared with every entry of a small associative buffer of recent page/frame pairs, all at the same time. When an entry matches, the frame number comes out of the buffer without any memory traffic. When no entry matches, the block makes exactly one read of the in-memory page table at table base plus page number. It then builds the physical address from the entry that comes back and stores the new pair in the buffer.

A table-base register and a table-length register describe the page table of the running process. The operating system loads both before it switches to a new process. Each load empties the buffer, so a translation from the old process cannot be used by the new one. Page numbers beyond the table length, and table entries marked not present, are reported to the requester. Neither case changes the buffer contents.

A requester raises `req_valid` with `req_vaddr` and holds both until `xl_done` pulses. The result flags and `xl_paddr` are valid in that cycle.

Top module: `xlate_unit`

## Requirements
- R1: On every completed translation, the low OFF_W bits of `xl_paddr` equal the offset of `req_vaddr`. When the translation succeeds, the upper bits of `xl_paddr` hold the frame number. When it fails, the upper bits are zero.
- R2: A page held in the buffer completes with `xl_hit`=1 and `xl_done` high in the cycle after acceptance. `mem_req` is never raised for it.
- R3: A page below the table length that is not in the buffer causes exactly one memory read at address base + page number. `mem_req` stays high, with `mem_addr` unchanged, until the cycle in which `mem_ack` is seen.
- R4: A table entry is present when bit MDATA_W-1 of `mem_rdata` is 1. Its frame number sits in bits FRAME_W-1:0. Such an entry is placed in the buffer, so the next access to the same page is a hit.
- R5: A page number equal to or above the table length completes in the cycle after acceptance with `xl_badpage`=1 and no memory read.
- R6: A table entry with bit MDATA_W-1 clear completes with `xl_fault`=1 and is not cached. A repeat access to that page reads memory again.
- R7: A `cfg_we` pulse loads both the table base and the table length and invalidates every buffer entry. The next access to any page is then a miss.
- R8: A new pair goes into the lowest-numbered empty entry. When every entry is valid, a round-robin pointer chooses the victim. The pointer starts at entry 0 after reset and advances by one on each such replacement.
- R9: After reset `xl_done` and `mem_req` are low. `xl_done` is high for exactly one cycle per request, and at most one of `xl_hit`, `xl_fault` and `xl_badpage` is set with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load table base and length; empties the buffer |
| cfg_base | input | MADDR_W | Memory address of the page table |
| cfg_len | input | PAGE_W+1 | Number of page-table entries |
| req_valid | input | 1 | Translation request, held until `xl_done` |
| req_vaddr | input | VA_W | Virtual address to translate |
| xl_done | output | 1 | One-cycle completion pulse |
| xl_paddr | output | FRAME_W+OFF_W | Physical address |
| xl_hit | output | 1 | Translation came from the buffer |
| xl_fault | output | 1 | Table entry not present |
| xl_badpage | output | 1 | Page number beyond table length |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MADDR_W | Page-table read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | MDATA_W | Page-table entry |

## Verification
The assertions check on every cycle the rules that do not depend on history. These are: a table read is held steady until it is acknowledged; the completion pulse lasts one cycle and carries at most one outcome flag; hits and bad pages complete without touching memory; and the offset passes through unchanged. Other behaviour only shows across a sequence of requests, so only the bench's scenarios can show it. This covers whether a pair was really cached, whether a faulting entry stays out of the buffer, whether a register load wipes earlier translations, and which entry the round-robin pointer evicts. The bench follows these with a reference model of the buffer.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WALK = 2'd1,
    XS_RESP = 2'd2
  } xstate_t;
endpackage

// File: rtl/xlate_cam.sv
// Associative page/frame buffer: parallel compare on the page tag.
module xlate_cam #(
  parameter int ENTRIES = 4,
  parameter int PAGE_W  = 8,
  parameter int FRAME_W = 8,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [PAGE_W-1:0]  look_page,
  output logic               look_hit,
  output logic [FRAME_W-1:0] look_frame,
  output logic [ENTRIES-1:0] vld_vec
);

  logic [ENTRIES-1:0] match_vec;
  logic [FRAME_W-1:0] frame_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic               v_q, v_d;
    logic [PAGE_W-1:0]  tag_q;
    logic [FRAME_W-1:0] frm_q;
    logic               wr_en;

    assign wr_en = fill_en && (fill_idx == IDX_W'(g));

    always_comb begin
      v_d = v_q;
      if (flush)      v_d = 1'b0;
      else if (wr_en) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q <= fill_page;
        frm_q <= fill_frame;
      end
    end

    assign match_vec[g] = v_q && (tag_q == look_page);
    assign vld_vec[g]   = v_q;
    assign frame_arr[g] = frm_q;
  end

  always_comb begin
    look_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) look_frame = look_frame | frame_arr[i];
    end
  end

  assign look_hit = |match_vec;

endmodule

// File: rtl/xlate_victim.sv
// Chooses the fill slot: lowest empty entry, else round-robin pointer.
module xlate_victim #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   slot
);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &vld_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign slot = all_full ? rr_q : free_idx;

  always_comb begin
    rr_d = rr_q;
    if (take && all_full) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_d = '0;
      else                             rr_d = rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

endmodule

// File: rtl/xlate_ctrl.sv
// Request sequencing, table registers and table-read port.
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int MADDR_W = 16,
  parameter int MDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [MADDR_W-1:0] cfg_base,
  input  logic [PAGE_W:0]    cfg_len,
  input  logic               req_valid,
  input  logic [PAGE_W-1:0]  req_page,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               cam_hit,
  input  logic [FRAME_W-1:0] cam_frame,
  input  logic               mem_ack,
  input  logic [MDATA_W-1:0] mem_rdata,
  output logic               fill_en,
  output logic [PAGE_W-1:0]  fill_page,
  output logic [FRAME_W-1:0] fill_frame,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  output logic               done,
  output logic [FRAME_W+OFF_W-1:0] paddr,
  output logic               hit,
  output logic               fault,
  output logic               badpage
);

  xstate_t            st_q, st_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic [MADDR_W-1:0] base_q, base_d;
  logic [PAGE_W:0]    len_q, len_d;
  logic               hit_q, hit_d, flt_q, flt_d, bad_q, bad_d;
  logic               ent_present;
  logic               unused_rdata_bits;

  assign ent_present       = mem_rdata[MDATA_W-1];
  assign unused_rdata_bits = ^mem_rdata[MDATA_W-2:FRAME_W];

  always_comb begin
    st_d    = st_q;
    page_d  = page_q;
    off_d   = off_q;
    frm_d   = frm_q;
    hit_d   = hit_q;
    flt_d   = flt_q;
    bad_d   = bad_q;
    fill_en = 1'b0;
    base_d  = cfg_we ? cfg_base : base_q;
    len_d   = cfg_we ? cfg_len  : len_q;
    unique case (st_q)
      XS_IDLE: begin
        if (req_valid) begin
          page_d = req_page;
          off_d  = req_off;
          frm_d  = '0;
          hit_d  = 1'b0;
          flt_d  = 1'b0;
          bad_d  = 1'b0;
          if ({1'b0, req_page} >= len_q) begin
            bad_d = 1'b1;
            st_d  = XS_RESP;
          end else if (cam_hit) begin
            hit_d = 1'b1;
            frm_d = cam_frame;
            st_d  = XS_RESP;
          end else begin
            st_d  = XS_WALK;
          end
        end
      end
      XS_WALK: begin
        if (mem_ack) begin
          st_d = XS_RESP;
          if (ent_present) begin
            frm_d   = mem_rdata[FRAME_W-1:0];
            fill_en = 1'b1;
          end else begin
            flt_d = 1'b1;
          end
        end
      end
      XS_RESP: st_d = XS_IDLE;
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      page_q <= '0;
      off_q  <= '0;
      frm_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      hit_q  <= 1'b0;
      flt_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
      off_q  <= off_d;
      frm_q  <= frm_d;
      base_q <= base_d;
      len_q  <= len_d;
      hit_q  <= hit_d;
      flt_q  <= flt_d;
      bad_q  <= bad_d;
    end
  end

  assign fill_page  = page_q;
  assign fill_frame = mem_rdata[FRAME_W-1:0];
  assign mem_req    = (st_q == XS_WALK);
  assign mem_addr   = base_q + MADDR_W'(page_q);
  assign done       = (st_q == XS_RESP);
  assign paddr      = {frm_q, off_q};
  assign hit        = done && hit_q;
  assign fault      = done && flt_q;
  assign badpage    = done && bad_q;

endmodule

// File: rtl/xlate_unit.sv
module xlate_unit #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ENTRIES = 4,
  parameter int MADDR_W = 16,
  parameter int MDATA_W = 16,
  localparam int PAGE_W = VA_W - OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [MADDR_W-1:0] cfg_base,
  input  logic [PAGE_W:0]    cfg_len,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               xl_done,
  output logic [PA_W-1:0]    xl_paddr,
  output logic               xl_hit,
  output logic               xl_fault,
  output logic               xl_badpage,
  output logic               mem_req,
  output logic [MADDR_W-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [MDATA_W-1:0] mem_rdata
);

  logic [PAGE_W-1:0]  va_page;
  logic [OFF_W-1:0]   va_off;
  logic               cam_hit;
  logic [FRAME_W-1:0] cam_frame;
  logic [ENTRIES-1:0] vld_vec;
  logic               fill_en;
  logic [IDX_W-1:0]   fill_idx;
  logic [PAGE_W-1:0]  fill_page;
  logic [FRAME_W-1:0] fill_frame;

  assign va_page = req_vaddr[VA_W-1:OFF_W];
  assign va_off  = req_vaddr[OFF_W-1:0];

  xlate_cam #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(cfg_we),
    .fill_en(fill_en), .fill_idx(fill_idx),
    .fill_page(fill_page), .fill_frame(fill_frame),
    .look_page(va_page), .look_hit(cam_hit), .look_frame(cam_frame),
    .vld_vec(vld_vec)
  );

  xlate_victim #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .clk(clk), .rst_n(rst_n), .vld_vec(vld_vec), .take(fill_en),
    .slot(fill_idx)
  );

  xlate_ctrl #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
    .MADDR_W(MADDR_W), .MDATA_W(MDATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .req_valid(req_valid), .req_page(va_page), .req_off(va_off),
    .cam_hit(cam_hit), .cam_frame(cam_frame),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fill_en(fill_en), .fill_page(fill_page), .fill_frame(fill_frame),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .done(xl_done), .paddr(xl_paddr),
    .hit(xl_hit), .fault(xl_fault), .badpage(xl_badpage)
  );

endmodule

// File: rtl/xlate_unit_chk.sv
module xlate_unit_chk #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int PA_W    = 16,
  parameter int MADDR_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               xl_done,
  input logic [PA_W-1:0]    xl_paddr,
  input logic               xl_hit,
  input logic               xl_fault,
  input logic               xl_badpage,
  input logic               mem_req,
  input logic [MADDR_W-1:0] mem_addr,
  input logic               mem_ack
);

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && req_valid) |-> (xl_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]));

  p_hit_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && xl_hit) |-> !$past(mem_req));

  p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_req_not_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !xl_done);

  p_bad_no_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && xl_badpage) |-> !$past(mem_req));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |=> !xl_done);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({xl_hit, xl_fault, xl_badpage}) <= 1);

  p_flags_need_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_hit || xl_fault || xl_badpage) |-> xl_done);

endmodule

bind xlate_unit xlate_unit_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .MADDR_W(MADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .xl_done(xl_done), .xl_paddr(xl_paddr), .xl_hit(xl_hit),
  .xl_fault(xl_fault), .xl_badpage(xl_badpage),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/xlate_unit_test.sv
`timescale 1ns/1ps
module xlate_unit_test;
  localparam int VA_W = 16, OFF_W = 8, FRAME_W = 8, ENTRIES = 4;
  localparam int MADDR_W = 16, MDATA_W = 16, PAGE_W = VA_W - OFF_W;

  logic clk, rst_n, cfg_we, req_valid, mem_ack;
  logic [MADDR_W-1:0] cfg_base;
  logic [PAGE_W:0] cfg_len;
  logic [VA_W-1:0] req_vaddr;
  logic [MDATA_W-1:0] mem_rdata;
  logic xl_done, xl_hit, xl_fault, xl_badpage, mem_req;
  logic [FRAME_W+OFF_W-1:0] xl_paddr;
  logic [MADDR_W-1:0] mem_addr;

  int total = 0, bad = 0;
  int nreads = 0;
  int last_addr = 0;
  int dly = 0;
  int cur_base = 0, cur_len = 0;
  int m_page [ENTRIES];
  bit m_vld [ENTRIES];
  int m_rr = 0;

  xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_len(cfg_len), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .xl_done(xl_done), .xl_paddr(xl_paddr), .xl_hit(xl_hit),
    .xl_fault(xl_fault), .xl_badpage(xl_badpage), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit tbl_present(int a);
    return (a % 5) != 0;
  endfunction

  function automatic int tbl_frame(int a);
    return (a * 37 + 11) & 8'hff;
  endfunction

  // Page-table memory with a random 0..2 cycle latency.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      dly = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (dly == 0) begin
        mem_ack = 1'b1;
        last_addr = int'(mem_addr);
        mem_rdata = {tbl_present(int'(mem_addr)), 7'd0, 8'(tbl_frame(int'(mem_addr)))};
        nreads++;
        dly = int'($urandom % 3);
      end else begin
        dly--;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_find(int p);
    for (int i = 0; i < ENTRIES; i++) if (m_vld[i] && m_page[i] == p) return i;
    return -1;
  endfunction

  task automatic m_fill(int p);
    int slot = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % ENTRIES;
    end
    m_vld[slot] = 1'b1;
    m_page[slot] = p;
  endtask

  task automatic load_cfg(int base, int len);
    cfg_we = 1'b1;
    cfg_base = MADDR_W'(base);
    cfg_len = (PAGE_W + 1)'(len);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_base = base;
    cur_len = len;
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
  endtask

  // Runs one translation from a negedge; returns the observed hit flag.
  task automatic xlate(int va, output bit got_hit);
    int p = (va >> OFF_W) & ((1 << PAGE_W) - 1);
    int off = va & ((1 << OFF_W) - 1);
    int addr = cur_base + p;
    bit e_bad = (p >= cur_len);
    bit e_hit = !e_bad && (m_find(p) >= 0);
    bit e_miss = !e_bad && !e_hit;
    bit e_flt = e_miss && !tbl_present(addr);
    int e_pa = (e_bad || e_flt) ? off : ((tbl_frame(addr) << OFF_W) | off);
    int r0 = nreads;
    int cyc = 0;
    if (e_miss && !e_flt) m_fill(p);
    req_valid = 1'b1;
    req_vaddr = VA_W'(va);
    do begin
      @(negedge clk);
      cyc++;
    end while (!xl_done && cyc < 60);
    chk(xl_done, "R9 completion seen", int'(xl_done), 1);
    got_hit = xl_hit;
    chk(xl_paddr == (FRAME_W + OFF_W)'(e_pa), "R1 physical address", int'(xl_paddr), e_pa);
    chk(xl_hit == e_hit, e_hit ? "R4 cached pair hits" : "R2 hit flag", int'(xl_hit), int'(e_hit));
    chk(xl_badpage == e_bad, "R5 bad page flag", int'(xl_badpage), int'(e_bad));
    chk(xl_fault == e_flt, "R6 fault flag", int'(xl_fault), int'(e_flt));
    chk((nreads - r0) == int'(e_miss), "R3 memory reads", nreads - r0, int'(e_miss));
    if (e_miss) chk(last_addr == addr, "R3 table address", last_addr, addr);
    if (e_hit) chk(cyc == 1, "R2 hit latency", cyc, 1);
    if (e_bad) chk(cyc == 1, "R5 bad page latency", cyc, 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!xl_done, "R9 single-cycle done", int'(xl_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit h;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_we = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    cfg_base = '0; cfg_len = '0; mem_ack = 1'b0; mem_rdata = '0;
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(!xl_done && !mem_req, "R9 reset outputs", int'({xl_done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Base 0x100: pages 4, 9 and 14 are not present.
    load_cfg(16'h0100, 12);
    xlate(16'h0123, h);                       // R3 miss, R4 fill
    xlate(16'h01ab, h);                       // R2 hit, new offset
    chk(h == 1'b1, "R4 repeat is hit", int'(h), 1);
    xlate(16'h0c00, h);                       // R5 page == length
    xlate(16'hff07, h);                       // R5 top page
    xlate(16'h0401, h);                       // R6 fault
    xlate(16'h0402, h);                       // R6 not cached: reads again
    chk(h == 1'b0, "R6 fault not cached", int'(h), 0);

    // R8: fill the rest, then replacement walks entries from 0.
    xlate(16'h0210, h); xlate(16'h0310, h); xlate(16'h0510, h);
    xlate(16'h0610, h);                       // evicts page 1 (entry 0)
    xlate(16'h0220, h);
    chk(h == 1'b1, "R8 page 2 survives", int'(h), 1);
    xlate(16'h0120, h);                       // evicts page 2 (entry 1)
    chk(h == 1'b0, "R8 page 1 was evicted", int'(h), 0);
    xlate(16'h0230, h);
    chk(h == 1'b0, "R8 page 2 now evicted", int'(h), 0);

    // R7: reload wipes everything, even with the same table.
    load_cfg(16'h0100, 12);
    xlate(16'h0330, h);
    chk(h == 1'b0, "R7 miss after reload", int'(h), 0);
    load_cfg(16'h0200, 3);
    xlate(16'h0330, h);                       // R5 under new length

    for (int n = 0; n < 400; n++) begin
      if (($urandom % 40) == 0)
        load_cfg(int'($urandom % 16'h0400), 4 + int'($urandom % 12));
      xlate(int'({8'($urandom % 18), 8'($urandom)}), h);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule